// File: doc/BRIEF.md
# Word-to-Byte Packing Front End

This block connects a 32-bit register port to the two 8-bit FIFOs of a serial flash controller. A write to one of the transmit data ports is broken into one to four bytes that go into the transmit byte FIFO one per clock. A read request takes bytes from the receive byte FIFO one per clock and builds them into a 32-bit word. A configuration bit sets the byte order for both directions.

While a transfer is under way the block raises `busy` and accepts no new access. A full transmit FIFO ends a write early, and the bytes that were not sent are discarded. An empty receive FIFO ends a read early, and the missing byte lanes read as zero. In little-endian order the partial word is moved up so that it is left-justified. An internal cache-fill path can force single-byte, little-endian transfers whatever the configuration says.

Top module: `word_byte_packer`

## Requirements
- R1: With `cfg_big_endian`=1, a write sends bits 31:24 first, then 23:16, 15:8 and 7:0, stopping after the byte count.
- R2: With `cfg_big_endian`=0, a write sends bits 7:0 first, then 15:8, 23:16 and 31:24, stopping after the byte count.
- R3: A write stops as soon as `tx_full` is high in a transfer cycle. No push happens in that cycle, the remaining bytes are discarded, and `busy` falls on the next clock.
- R4: `wr_port`=0 sends the configured length, where `cfg_len_code` values 0, 1, 2 and 3 mean 1, 2, 3 and 4 bytes. `wr_port` values 1, 2 and 3 send exactly that many bytes.
- R5: `cfg_big_endian` is sampled in the cycle the access is accepted: 1 selects big-endian order and 0 selects little-endian order.
- R6: A read pops one byte per clock while `rx_empty` is low, up to the configured length. Byte lanes that no pop filled read as zero.
- R7: In a big-endian read, the first popped byte lands in bits 31:24, the second in 23:16, and so on.
- R8: In a little-endian read, the first popped byte lands in bits 7:0, the second in 15:8, and so on. The word is then shifted left by 8 times (requested minus popped). When nothing is popped, the result is zero.
- R9: An access is accepted only in a cycle where `busy` is low. `busy` is high from the clock after acceptance until the transfer ends. Requests made while busy are ignored, and no push or pop happens while `busy` is low.
- R10: `rd_valid` pulses for exactly one cycle, one clock after the last pop (or after the cycle that found the FIFO empty). `rd_word` holds its value at all other times. Reset clears both.
- R11: With `fill_mode`=1 at acceptance, the access moves exactly one byte in little-endian order, whatever the values of `cfg_big_endian`, `cfg_len_code` and `wr_port`.
- R12: When `wr_req` and `rd_req` are both high in an idle cycle, the write is accepted and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_big_endian | input | 1 | Byte order: 1 big-endian, 0 little-endian |
| cfg_len_code | input | 2 | Configured transfer length minus one |
| wr_req | input | 1 | Transmit write request |
| wr_port | input | 2 | 0 selects the configured length, 1 to 3 select a fixed byte count |
| wr_word | input | 32 | Word to split |
| rd_req | input | 1 | Receive read request |
| fill_mode | input | 1 | Forces one byte in little-endian order |
| busy | output | 1 | Transfer in progress |
| rd_word | output | 32 | Assembled receive word |
| rd_valid | output | 1 | One-cycle strobe marking a new `rd_word` |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_byte | output | 8 | Byte being pushed |
| tx_full | input | 1 | Transmit FIFO full |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_byte | input | 8 | Head byte of the receive FIFO |
| rx_empty | input | 1 | Receive FIFO empty |

## Verification
The hardest cases to reach are a FIFO that changes state part-way through a word: a transmit FIFO that fills after two bytes, or a receive FIFO that holds fewer bytes than requested. In the little-endian case the shortfall shift must then be applied. The bench models both FIFOs as queues of its own, whose fill level drives `tx_full` and `rx_empty`. It preloads the transmit queue to two slots below its capacity before a four-byte write. It loads the receive queue with zero, one or two bytes before reads of up to four. Requests issued while `busy` is high, and simultaneous read and write requests, are checked by confirming that the receive queue is left untouched.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TX   = 2'd1,
    PH_RX   = 2'd2
  } phase_e;
endpackage

// File: rtl/wbp_tx_lane.sv
module wbp_tx_lane #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  load_len,
  input  logic              load_be,
  input  logic              step,
  output logic [BYTE_W-1:0] cur_byte,
  output logic              last
);
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      be_q   <= 1'b0;
    end else if (load) begin
      sh_q   <= load_word;
      left_q <= load_len;
      be_q   <= load_be;
    end else if (step) begin
      sh_q   <= be_q ? (sh_q << BYTE_W) : (sh_q >> BYTE_W);
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign cur_byte = be_q ? sh_q[WORD_W-1 -: BYTE_W] : sh_q[BYTE_W-1:0];
  assign last     = (left_q == CNT_W'(1));

  // R4: never push more bytes than were loaded
  assert_push_bound_R4: assert property (@(posedge clk) disable iff (rst)
    step |-> (left_q != '0));
endmodule

// File: rtl/wbp_rx_lane.sv
module wbp_rx_lane #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_len,
  input  logic              start_be,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              finish,
  output logic              last,
  output logic [WORD_W-1:0] word,
  output logic              valid
);
  localparam int NB = WORD_W / BYTE_W;

  logic [WORD_W-1:0] acc_q, acc_n, packed_w;
  logic [CNT_W-1:0]  got_q, got_n, want_q, short_n;
  logic              be_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  for (genvar j = 0; j < NB; j++) begin : g_lane
    logic hit;
    assign hit = take && (be_q ? (got_q == CNT_W'(NB - 1 - j)) : (got_q == CNT_W'(j)));
    assign acc_n[j*BYTE_W +: BYTE_W] = hit ? byte_in : acc_q[j*BYTE_W +: BYTE_W];
  end

  assign got_n   = got_q + CNT_W'(take);
  assign short_n = want_q - got_n;

  always_comb begin
    if (be_q)                packed_w = acc_n;
    else if (got_n == '0)    packed_w = '0;
    else                     packed_w = acc_n << (BYTE_W * int'(short_n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      got_q   <= '0;
      want_q  <= '0;
      be_q    <= 1'b0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start) begin
        acc_q  <= '0;
        got_q  <= '0;
        want_q <= start_len;
        be_q   <= start_be;
      end else begin
        acc_q <= acc_n;
        got_q <= got_n;
      end
      if (finish) begin
        word_q  <= packed_w;
        valid_q <= 1'b1;
      end
    end
  end

  assign last  = ((got_q + CNT_W'(1)) == want_q);
  assign word  = word_q;
  assign valid = valid_q;

  // R6: never pop past the requested length
  assert_take_bound_R6: assert property (@(posedge clk) disable iff (rst)
    take |-> (got_q < want_q));
endmodule

// File: rtl/word_byte_packer.sv
module word_byte_packer
  import wbp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = WORD_W / BYTE_W,
  localparam int SEL_W = $clog2(NB),
  localparam int CNT_W = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_big_endian,
  input  logic [SEL_W-1:0]  cfg_len_code,
  input  logic              wr_req,
  input  logic [SEL_W-1:0]  wr_port,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_req,
  input  logic              fill_mode,
  output logic              busy,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_valid,
  output logic              tx_push,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_full,
  output logic              rx_pop,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_empty
);
  phase_e           phase_q;
  logic             idle, acc_wr, acc_rd, eff_be;
  logic [CNT_W-1:0] cfg_len, wr_len, rd_len;
  logic             tx_last, rx_last, rx_finish;

  assign idle    = (phase_q == PH_IDLE);
  assign acc_wr  = idle && wr_req;
  assign acc_rd  = idle && rd_req && !wr_req;
  assign cfg_len = CNT_W'(cfg_len_code) + CNT_W'(1);
  assign wr_len  = fill_mode ? CNT_W'(1) :
                   ((wr_port == '0) ? cfg_len : CNT_W'(wr_port));
  assign rd_len  = fill_mode ? CNT_W'(1) : cfg_len;
  assign eff_be  = cfg_big_endian && !fill_mode;

  assign tx_push   = (phase_q == PH_TX) && !tx_full;
  assign rx_pop    = (phase_q == PH_RX) && !rx_empty;
  assign rx_finish = (phase_q == PH_RX) && (rx_empty || rx_last);
  assign busy      = !idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (acc_wr)      phase_q <= PH_TX;
          else if (acc_rd) phase_q <= PH_RX;
        end
        PH_TX:   if (tx_full || tx_last) phase_q <= PH_IDLE;
        PH_RX:   if (rx_finish)          phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  wbp_tx_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .load(acc_wr), .load_word(wr_word), .load_len(wr_len),
    .load_be(eff_be), .step(tx_push), .cur_byte(tx_byte), .last(tx_last)
  );

  wbp_rx_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .start(acc_rd), .start_len(rd_len), .start_be(eff_be),
    .take(rx_pop), .byte_in(rx_byte), .finish(rx_finish), .last(rx_last),
    .word(rd_word), .valid(rd_valid)
  );

  // R10: read strobe lasts one cycle
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  // R10: read word changes only together with the strobe
  assert_word_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_word));
  // R9: no FIFO traffic while idle
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!tx_push && !rx_pop));
  // R9: an accepted request raises busy on the next clock
  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && (wr_req || rd_req)) |=> busy);
endmodule

// File: tb/word_byte_packer_tb_top.sv
module word_byte_packer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TXCAP      = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_big_endian = 1'b0;
  logic [1:0]  cfg_len_code = 2'd0;
  logic        wr_req = 1'b0;
  logic [1:0]  wr_port = 2'd0;
  logic [31:0] wr_word = '0;
  logic        rd_req = 1'b0;
  logic        fill_mode = 1'b0;
  logic        busy, rd_valid, tx_push, rx_pop;
  logic [31:0] rd_word;
  logic [7:0]  tx_byte;
  logic        tx_full = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_empty = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  word_byte_packer dut_i (
    .clk(clk), .rst(rst), .cfg_big_endian(cfg_big_endian), .cfg_len_code(cfg_len_code),
    .wr_req(wr_req), .wr_port(wr_port), .wr_word(wr_word), .rd_req(rd_req),
    .fill_mode(fill_mode), .busy(busy), .rd_word(rd_word), .rd_valid(rd_valid),
    .tx_push(tx_push), .tx_byte(tx_byte), .tx_full(tx_full), .rx_pop(rx_pop),
    .rx_byte(rx_byte), .rx_empty(rx_empty)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_valid = 0;
  logic [31:0] last_rd = '0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] seen[$];

  // reference model state
  int          m_ph = 0;
  logic [7:0]  m_out[$];
  logic [7:0]  m_got[$];
  int          m_want = 0;
  logic        m_be = 1'b0;
  logic [31:0] m_word = '0;
  logic        m_val = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic refresh();
    tx_full  = (txq.size() >= TXCAP);
    rx_empty = (rxq.size() == 0);
    rx_byte  = (rxq.size() != 0) ? rxq[0] : 8'h00;
  endtask

  function automatic logic [31:0] build_word(input logic [7:0] g[$], input int want, input logic be);
    logic [31:0] w = '0;
    int sf;
    for (int k = 0; k < g.size(); k++)
      if (be) w = w | (32'(g[k]) << (24 - 8*k));
      else    w = w | (32'(g[k]) << (8*k));
    sf = want - g.size();
    if (!be) w = (sf >= 4) ? 32'h0 : (w << (8*sf));
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_out.delete(); m_got.delete(); m_word = '0; m_val = 1'b0;
    end else begin
      m_val = 1'b0;
      case (m_ph)
        0: begin
          if (wr_req) begin
            int n;
            logic be;
            n  = fill_mode ? 1 : ((wr_port == 2'd0) ? int'(cfg_len_code) + 1 : int'(wr_port));
            be = cfg_big_endian && !fill_mode;
            for (int k = 0; k < n; k++)
              m_out.push_back(be ? 8'(wr_word >> (24 - 8*k)) : 8'(wr_word >> (8*k)));
            m_ph = 1;
          end else if (rd_req) begin
            m_want = fill_mode ? 1 : int'(cfg_len_code) + 1;
            m_be   = cfg_big_endian && !fill_mode;
            m_got.delete();
            m_ph = 2;
          end
        end
        1: begin
          if (txq.size() >= TXCAP) begin
            m_out.delete(); m_ph = 0;
          end else begin
            txq.push_back(m_out.pop_front());
            if (m_out.size() == 0) m_ph = 0;
          end
        end
        default: begin
          bit was_empty;
          was_empty = (rxq.size() == 0);
          if (!was_empty) m_got.push_back(rxq.pop_front());
          if (was_empty || m_got.size() == m_want) begin
            m_word = build_word(m_got, m_want, m_be);
            m_val  = 1'b1;
            m_ph   = 0;
          end
        end
      endcase
    end
    tx_full  <= (txq.size() >= TXCAP);
    rx_empty <= (rxq.size() == 0);
    rx_byte  <= (rxq.size() != 0) ? rxq[0] : 8'h00;
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      chk(busy == (m_ph != 0), "R9 busy", 32'(busy), 32'(m_ph != 0));
      chk(tx_push == (m_ph == 1 && !tx_full), "R3 tx_push", 32'(tx_push), 32'(m_ph == 1 && !tx_full));
      if (tx_push && m_ph == 1 && m_out.size() != 0)
        chk(tx_byte == m_out[0], "R1/R2 tx_byte", 32'(tx_byte), 32'(m_out[0]));
      chk(rx_pop == (m_ph == 2 && !rx_empty), "R6 rx_pop", 32'(rx_pop), 32'(m_ph == 2 && !rx_empty));
      chk(rd_valid == m_val, "R10 rd_valid", 32'(rd_valid), 32'(m_val));
      chk(rd_word == m_word, "R10 rd_word", rd_word, m_word);
      if (tx_push) seen.push_back(tx_byte);
      if (rd_valid) begin n_valid++; last_rd = rd_word; end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op_write(input logic [1:0] port, input logic [31:0] w, input logic be,
                          input logic [1:0] len, input logic fill);
    @(negedge clk);
    while (busy) @(negedge clk);
    cfg_big_endian = be; cfg_len_code = len; wr_port = port; wr_word = w;
    fill_mode = fill; wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0; fill_mode = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op_read(input logic be, input logic [1:0] len, input logic fill);
    @(negedge clk);
    while (busy) @(negedge clk);
    cfg_big_endian = be; cfg_len_code = len; fill_mode = fill; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; fill_mode = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_seen(input string tag, input logic [7:0] e[$]);
    chk(seen.size() == e.size(), {tag, " byte count"}, 32'(seen.size()), 32'(e.size()));
    for (int k = 0; k < e.size() && k < seen.size(); k++)
      chk(seen[k] == e[k], tag, 32'(seen[k]), 32'(e[k]));
    seen.delete();
    txq.delete();
    refresh();
  endtask

  task automatic check_read(input string tag, input logic [31:0] exp, input int v0);
    chk(n_valid == v0 + 1, {tag, " one strobe (R10)"}, 32'(n_valid), 32'(v0 + 1));
    chk(last_rd == exp, tag, last_rd, exp);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // reset state (R9, R10)
    chk(busy == 1'b0, "R9 reset busy", 32'(busy), 0);
    chk(rd_valid == 1'b0, "R10 reset rd_valid", 32'(rd_valid), 0);
    chk(rd_word == 32'h0, "R10 reset rd_word", rd_word, 0);
    chk(tx_push == 1'b0, "R9 reset tx_push", 32'(tx_push), 0);

    // R1, R4, R5: big-endian, configured length 4
    op_write(2'd0, 32'hA1B2C3D4, 1'b1, 2'd3, 1'b0);
    check_seen("R1 BE four bytes", '{8'hA1, 8'hB2, 8'hC3, 8'hD4});
    // R2, R4: little-endian, fixed 2 bytes
    op_write(2'd2, 32'h11223344, 1'b0, 2'd3, 1'b0);
    check_seen("R2 LE port2", '{8'h44, 8'h33});
    // R4: fixed 3 bytes LE, fixed 1 byte BE, configured 2 bytes BE
    op_write(2'd3, 32'h55667788, 1'b0, 2'd0, 1'b0);
    check_seen("R4 port3", '{8'h88, 8'h77, 8'h66});
    op_write(2'd1, 32'h9ABCDEF0, 1'b1, 2'd3, 1'b0);
    check_seen("R4 port1 R5", '{8'h9A});
    op_write(2'd0, 32'h0F1E2D3C, 1'b1, 2'd1, 1'b0);
    check_seen("R4 cfg len2", '{8'h0F, 8'h1E});

    // R3: FIFO fills after two bytes
    txq = '{8'h00, 8'h00, 8'h00, 8'h00}; refresh();
    op_write(2'd0, 32'hDEADBEEF, 1'b1, 2'd3, 1'b0);
    check_seen("R3 full midway", '{8'hDE, 8'hAD});
    // R3: FIFO full from the start
    txq = '{8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0}; refresh();
    op_write(2'd0, 32'h01020304, 1'b0, 2'd3, 1'b0);
    check_seen("R3 full at start", '{});

    // R11: fill write ignores BE, length and port
    op_write(2'd3, 32'h12345678, 1'b1, 2'd3, 1'b1);
    check_seen("R11 fill write", '{8'h78});

    // R7: full big-endian read
    rxq = '{8'h01, 8'h02, 8'h03, 8'h04}; refresh(); v0 = n_valid;
    op_read(1'b1, 2'd3, 1'b0);
    check_read("R7 BE read", 32'h01020304, v0);
    // R8: full little-endian read
    rxq = '{8'h01, 8'h02, 8'h03, 8'h04}; refresh(); v0 = n_valid;
    op_read(1'b0, 2'd3, 1'b0);
    check_read("R8 LE read", 32'h04030201, v0);
    // R8, R6: partial little-endian read, shortfall 2
    rxq = '{8'hAA, 8'hBB}; refresh(); v0 = n_valid;
    op_read(1'b0, 2'd3, 1'b0);
    check_read("R8 LE partial", 32'hBBAA0000, v0);
    // R6, R7: partial big-endian read
    rxq = '{8'hAA, 8'hBB}; refresh(); v0 = n_valid;
    op_read(1'b1, 2'd3, 1'b0);
    check_read("R6 BE partial", 32'hAABB0000, v0);
    // R8: one of three bytes
    rxq = '{8'h5A}; refresh(); v0 = n_valid;
    op_read(1'b0, 2'd2, 1'b0);
    check_read("R8 LE one of three", 32'h005A0000, v0);
    // R8, R6: empty FIFO in both orders
    v0 = n_valid;
    op_read(1'b0, 2'd3, 1'b0);
    check_read("R8 LE empty", 32'h0, v0);
    rxq = '{8'h77}; refresh(); v0 = n_valid;
    op_read(1'b1, 2'd0, 1'b0);
    check_read("R7 BE one byte", 32'h77000000, v0);
    v0 = n_valid;
    op_read(1'b1, 2'd3, 1'b0);
    check_read("R6 BE empty", 32'h0, v0);
    // R6: length 2 stops with a byte left over, then R11 fill read
    rxq = '{8'h05, 8'h06, 8'h07}; refresh(); v0 = n_valid;
    op_read(1'b0, 2'd1, 1'b0);
    check_read("R6 LE len2", 32'h00000605, v0);
    chk(rxq.size() == 1, "R6 leftover", 32'(rxq.size()), 1);
    v0 = n_valid;
    op_read(1'b1, 2'd3, 1'b1);
    check_read("R11 fill read", 32'h00000007, v0);

    // R9: read request while busy is ignored
    rxq = '{8'hC1, 8'hC2}; refresh(); v0 = n_valid;
    @(negedge clk);
    cfg_big_endian = 1'b1; cfg_len_code = 2'd3; wr_port = 2'd0; wr_word = 32'h10203040; wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    wait_idle();
    chk(rxq.size() == 2, "R9 ignored while busy", 32'(rxq.size()), 2);
    chk(n_valid == v0, "R9 no strobe", 32'(n_valid), 32'(v0));
    check_seen("R9 write intact", '{8'h10, 8'h20, 8'h30, 8'h40});

    // R12: simultaneous requests, write wins
    @(negedge clk);
    cfg_big_endian = 1'b0; cfg_len_code = 2'd0; wr_port = 2'd0; wr_word = 32'h000000E5;
    wr_req = 1'b1; rd_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0;
    wait_idle();
    chk(rxq.size() == 2, "R12 read ignored", 32'(rxq.size()), 2);
    chk(n_valid == v0, "R12 no strobe", 32'(n_valid), 32'(v0));
    check_seen("R12 write taken", '{8'hE5});

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule